// File: doc/BRIEF.md
# Serial Input Word Assembler

This block sits in front of a FIFO write port and turns a stream of single bits into words. Each serial bit arrives with a one-cycle bit strobe, which stands for a rising edge of the serial input clock. Bits are placed into an accumulator in arrival order. When the programmed number of bits has been gathered, the block issues one write strobe carrying the assembled word. A mode input bypasses all of this: the block then forwards a 9-bit parallel word and its valid flag straight to the write port.

A cascade enable input gates which strobes this block accepts. A companion output rises when a word completes, and the next block in a daisy chain can use it as its own cascade enable. A single block, or any block that runs in parallel mode, has the cascade input tied high. If the FIFO reports full at the moment a write would be issued, the word is discarded and a one-cycle overflow pulse is raised.

Top module: `serial_word_assembler`

## Requirements
- R1: While `rst` is high and in the cycle after it, `wr_en`, `ovf_pulse` and `casc_out` are 0. Any partly gathered serial word is discarded, so the first word after reset is built only from bits received after reset.
- R2: An accepted bit strobe stores `ser_bit` into the word. The first accepted bit of a word becomes bit 0, and the k-th accepted bit becomes bit k-1.
- R3: In serial mode, exactly one write is issued for every i accepted bits, where i is the effective width. `wr_en` is high for a single cycle, at the second rising edge after the edge that sampled the last bit.
- R4: Bits of `wr_data` at and above position i are 0 for a serial word. This also holds when the width is lowered in the middle of a word: the word then completes on the next accepted bit and is masked to the new width.
- R5: `width_sel` is an unsigned 4-bit word count. Values 1 to 9 select that width, 0 acts as 1, and 10 to 15 act as 9.
- R6: With `par_sel` high, each cycle with `par_valid` high writes `par_data` unchanged, one cycle later. Bit strobes are ignored, and any partial serial word is cleared.
- R7: If `fifo_full` is high at the edge where a write would be issued, no write happens. `ovf_pulse` is high for one cycle in the slot where `wr_en` would have been. `wr_en` is never high after a cycle in which `fifo_full` was high.
- R8: A bit strobe is accepted only when `ser_clk_en` is high, `casc_in` is high and `par_sel` is low. Strobes arriving while `casc_in` is low neither store a bit nor advance the count.
- R9: `casc_out` goes high in the cycle after a serial word completes and stays high until the next accepted bit, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_sel | input | 1 | 1 selects parallel mode, 0 selects serial mode |
| par_data | input | 9 | Parallel input word |
| par_valid | input | 1 | Parallel word present this cycle |
| ser_clk_en | input | 1 | Bit strobe, one cycle per serial clock rising edge |
| ser_bit | input | 1 | Serial data bit |
| width_sel | input | 4 | Serial word width code |
| casc_in | input | 1 | Cascade enable from the previous block, or tied high |
| fifo_full | input | 1 | FIFO full status |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 9 | FIFO write data |
| ovf_pulse | output | 1 | Word dropped because the FIFO was full |
| casc_out | output | 1 | Word-completed level for the next block in a chain |

## Verification
The assertions assume that `par_data` and the other inputs are steady at each clock edge. They also assume that reset is applied for at least one edge before any checks count, and that `width_sel` changes only in ways R4 and R5 cover. The stimulus drives every input on the falling clock edge and keeps reset high for several cycles. Outside the deliberate mid-word shrink test, it changes the width only between words. The FIFO full flag is raised only around whole words, so the write and overflow slots are never split.

// File: rtl/swa_pkg.sv
package swa_pkg;
  parameter int unsigned MAX_W = 9;
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);
  typedef logic [MAX_W-1:0] word_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/swa_width.sv
module swa_width
  import swa_pkg::*;
(
  input  cnt_t width_sel,
  output cnt_t width_eff
);
  // R5: code 0 acts as 1, codes above the maximum saturate
  always_comb begin
    if (width_sel == '0)
      width_eff = cnt_t'(1);
    else if (int'(width_sel) > int'(MAX_W))
      width_eff = cnt_t'(MAX_W);
    else
      width_eff = width_sel;
  end
endmodule

// File: rtl/swa_shift.sv
module swa_shift
  import swa_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  take,
  input  logic  bit_in,
  input  cnt_t  width_eff,
  output word_t word,
  output logic  word_vld,
  output logic  casc_flag
);
  word_t acc;
  cnt_t  cnt;
  cnt_t  cnt_nxt;
  word_t mask;
  word_t merged;

  always_comb begin
    mask = '0;
    for (int b = 0; b < int'(MAX_W); b++)
      if (b < int'(width_eff)) mask[b] = 1'b1;
    cnt_nxt = cnt + cnt_t'(1);
    merged  = acc | (word_t'(bit_in) << cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      word      <= '0;
      word_vld  <= 1'b0;
      casc_flag <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (clr) begin
        acc       <= '0;
        cnt       <= '0;
        casc_flag <= 1'b0;
      end else if (take) begin
        casc_flag <= 1'b0;
        if (cnt_nxt >= width_eff) begin
          word      <= merged & mask;
          word_vld  <= 1'b1;
          casc_flag <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= merged;
          cnt <= cnt_nxt;
        end
      end
    end
  end

  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < int'(MAX_W));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> ((word >> $past(width_eff)) == '0));

  a_r9_casc_with_word: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> casc_flag);
endmodule

// File: rtl/swa_wrgen.sv
module swa_wrgen
  import swa_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  par_sel,
  input  logic  par_valid,
  input  word_t par_data,
  input  logic  ser_vld,
  input  word_t ser_word,
  input  logic  fifo_full,
  output logic  wr_en,
  output word_t wr_data,
  output logic  ovf
);
  logic  req;
  word_t dat;
  logic  live;

  always_comb begin
    req = par_sel ? par_valid : ser_vld;
    dat = par_sel ? par_data : ser_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      ovf     <= 1'b0;
      wr_data <= '0;
      live    <= 1'b0;
    end else begin
      live  <= 1'b1;
      wr_en <= req & ~fifo_full;
      ovf   <= req & fifo_full;
      if (req && !fifo_full) wr_data <= dat;
    end
  end

  a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    (live && wr_en) |-> !$past(fifo_full));

  a_r7_ovf_excl: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ovf));

  a_r6_par_pass: assert property (@(posedge clk) disable iff (rst)
    (live && $past(par_sel && par_valid && !fifo_full)) |->
      (wr_en && wr_data == $past(par_data)));
endmodule

// File: rtl/serial_word_assembler.sv
module serial_word_assembler
  import swa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             par_sel,
  input  logic [MAX_W-1:0] par_data,
  input  logic             par_valid,
  input  logic             ser_clk_en,
  input  logic             ser_bit,
  input  logic [CNT_W-1:0] width_sel,
  input  logic             casc_in,
  input  logic             fifo_full,
  output logic             wr_en,
  output logic [MAX_W-1:0] wr_data,
  output logic             ovf_pulse,
  output logic             casc_out
);
  cnt_t  width_eff;
  word_t ser_word;
  logic  ser_vld;
  logic  take;

  // R8: a strobe counts only when enabled by the chain and in serial mode
  assign take = ser_clk_en & casc_in & ~par_sel;

  swa_width u_width (
    .width_sel (width_sel),
    .width_eff (width_eff)
  );

  swa_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .clr       (par_sel),
    .take      (take),
    .bit_in    (ser_bit),
    .width_eff (width_eff),
    .word      (ser_word),
    .word_vld  (ser_vld),
    .casc_flag (casc_out)
  );

  swa_wrgen u_wrgen (
    .clk       (clk),
    .rst       (rst),
    .par_sel   (par_sel),
    .par_valid (par_valid),
    .par_data  (par_data),
    .ser_vld   (ser_vld),
    .ser_word  (ser_word),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ovf       (ovf_pulse)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!wr_en && !ovf_pulse && !casc_out));
endmodule

// File: tb/serial_word_assembler_test.sv
module serial_word_assembler_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_sel = 1'b0;
  logic [8:0] par_data = '0;
  logic       par_valid = 1'b0;
  logic       ser_clk_en = 1'b0;
  logic       ser_bit = 1'b0;
  logic [3:0] width_sel = 4'd1;
  logic       casc_in = 1'b1;
  logic       fifo_full = 1'b0;
  logic       wr_en;
  logic [8:0] wr_data;
  logic       ovf_pulse;
  logic       casc_out;

  int total = 0;
  int fails = 0;
  int wr_cnt = 0;
  int ovf_cnt = 0;
  logic [8:0] cap [0:255];
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 1'b0;

  serial_word_assembler uut (
    .clk(clk), .rst(rst), .par_sel(par_sel), .par_data(par_data),
    .par_valid(par_valid), .ser_clk_en(ser_clk_en), .ser_bit(ser_bit),
    .width_sel(width_sel), .casc_in(casc_in), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .ovf_pulse(ovf_pulse),
    .casc_out(casc_out)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        cap[wr_cnt % 256] = wr_data;
        wr_cnt++;
      end
      if (ovf_pulse) ovf_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input int w, input int val);
    for (int b = 0; b < w; b++) begin
      @(negedge clk);
      ser_clk_en = 1'b1;
      ser_bit = val[b];
    end
    @(negedge clk);
    ser_clk_en = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    int expv;
    repeat (3) @(negedge clk);
    check(!wr_en && !ovf_pulse && !casc_out, "R1 outputs in reset",
          {wr_en, ovf_pulse, casc_out}, 0);
    rst = 1'b0;

    // R1: partial word lost across reset
    width_sel = 4'd5;
    send_word(3, 7);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!wr_en && !casc_out, "R1 quiet after reset", {wr_en, casc_out}, 0);
    base = wr_cnt;
    send_word(5, 5'b10010);
    drain();
    check(wr_cnt == base + 1 && cap[base % 256] == 9'h012, "R1 fresh word",
          cap[base % 256], 9'h012);

    // R2/R3/R9: exact timing and bit order
    width_sel = 4'd4;
    base = wr_cnt;
    send_word(4, 4'b1011);
    check(!wr_en, "R3 no write yet", wr_en, 0);
    check(casc_out, "R9 casc high on completion", casc_out, 1);
    @(negedge clk);
    check(wr_en && wr_data == 9'h00B, "R2 R3 write slot", wr_data, 9'h00B);
    @(negedge clk);
    check(!wr_en, "R3 single cycle", wr_en, 0);
    send_word(1, 1);
    check(!casc_out, "R9 casc cleared by next bit", casc_out, 0);
    send_word(3, 0);
    drain();
    check(wr_cnt == base + 2 && cap[(base + 1) % 256] == 9'h001, "R2 partial finish",
          cap[(base + 1) % 256], 9'h001);

    // R3/R4: sweep every width
    for (int w = 1; w <= 9; w++) begin
      width_sel = 4'(w);
      for (int k = 0; k < 4; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        expv = int'(lfsr) & ((1 << w) - 1);
        base = wr_cnt;
        send_word(w, int'(lfsr));
        drain();
        check(wr_cnt == base + 1 && cap[base % 256] == 9'(expv),
              "R3 R4 sweep word", cap[base % 256], expv);
      end
    end

    // R5: width codes 0 and 13
    width_sel = 4'd0;
    base = wr_cnt;
    send_word(1, 1);
    send_word(1, 0);
    drain();
    check(wr_cnt == base + 2 && cap[base % 256] == 9'h001 && cap[(base + 1) % 256] == 9'h000,
          "R5 code zero", wr_cnt - base, 2);
    width_sel = 4'd13;
    base = wr_cnt;
    send_word(9, 9'h15A);
    drain();
    check(wr_cnt == base + 1 && cap[base % 256] == 9'h15A, "R5 code saturates",
          cap[base % 256], 9'h15A);

    // R4: shrink width mid-word
    width_sel = 4'd9;
    base = wr_cnt;
    send_word(5, 5'b11111);
    width_sel = 4'd3;
    send_word(1, 1);
    drain();
    check(wr_cnt == base + 1 && cap[base % 256] == 9'h007, "R4 shrink masks",
          cap[base % 256], 9'h007);

    // R8: cascade gating
    width_sel = 4'd3;
    base = wr_cnt;
    send_word(1, 1);
    casc_in = 1'b0;
    send_word(4, 4'b1111);
    drain();
    check(wr_cnt == base, "R8 gated strobes", wr_cnt - base, 0);
    casc_in = 1'b1;
    send_word(2, 2'b10);
    drain();
    check(wr_cnt == base + 1 && cap[base % 256] == 9'h005, "R8 count held",
          cap[base % 256], 9'h005);

    // R6: parallel pass and serial clear
    par_sel = 1'b1;
    base = wr_cnt;
    @(negedge clk);
    par_data = 9'h1A5;
    par_valid = 1'b1;
    @(negedge clk);
    par_valid = 1'b0;
    check(wr_en && wr_data == 9'h1A5, "R6 parallel write", wr_data, 9'h1A5);
    drain();
    check(wr_cnt == base + 1, "R6 single parallel write", wr_cnt - base, 1);
    par_sel = 1'b0;
    width_sel = 4'd2;
    base = wr_cnt;
    send_word(1, 1);
    par_sel = 1'b1;
    send_word(1, 1);
    drain();
    check(wr_cnt == base, "R6 strobe ignored", wr_cnt - base, 0);
    par_sel = 1'b0;
    send_word(2, 0);
    drain();
    check(wr_cnt == base + 1 && cap[base % 256] == 9'h000, "R6 partial cleared",
          cap[base % 256], 0);

    // R7: full drops word
    fifo_full = 1'b1;
    width_sel = 4'd3;
    base = wr_cnt;
    expv = ovf_cnt;
    send_word(3, 3'b110);
    drain();
    check(wr_cnt == base && ovf_cnt == expv + 1, "R7 serial drop", ovf_cnt - expv, 1);
    par_sel = 1'b1;
    @(negedge clk);
    par_valid = 1'b1;
    par_data = 9'h0FF;
    @(negedge clk);
    par_valid = 1'b0;
    check(ovf_pulse && !wr_en, "R7 parallel drop", {ovf_pulse, wr_en}, 2);
    @(negedge clk);
    check(!ovf_pulse, "R7 one cycle pulse", ovf_pulse, 0);
    fifo_full = 1'b0;
    par_sel = 1'b0;
    drain();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule